// File: doc/BRIEF.md
# Bi-Mode Conditional Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two banks of saturating counters. One bank starts out leaning not-taken and the other starts out leaning taken. A row in either bank is picked by XOR-ing the branch address bits with a global history of recent outcomes. A third table of counters, picked by the branch address alone, chooses which bank answers. Because each bank sees mostly branches of one bias, two branches that share a row seldom pull it in opposite ways.

The fetch side presents the branch address bits on the predict port. In the same cycle it gets back the taken bit, the bank that answered and the row that was read, and it keeps the bank and row with the branch. When the branch resolves, the back end returns the address, the real outcome, and the saved row and bank on the update port. The update trains the chosen counters and shifts the outcome into the history. The address ports carry only the low address bits the tables use, with the alignment bits already removed.

Top module: `bimode_predictor`

## Requirements
- R1: After reset, every not-taken-bank counter holds 01, every taken-bank counter holds 10, every choice counter holds 10, and the history is all zeros. A fresh address therefore reports bank 1 and predicts taken.
- R2: `pred_idx` equals `pred_pc` XOR the global history, and that row is the one read in both banks.
- R3: The top bit of the choice counter at row `pred_pc` selects the bank. 1 selects the taken bank and 0 selects the not-taken bank, and `pred_bank` reports the choice.
- R4: Counters are 2 bits wide. `pred_taken` is the top bit of the selected bank's counter at `pred_idx`.
- R5: An update adds one to the trained bank counter on taken and subtracts one on not-taken. It stops at 11 and at 00 and never wraps.
- R6: Each update shifts the outcome into bit 0 of the history, and the oldest bit falls out.
- R7: An update trains only the bank named by `upd_bank`, at row `upd_idx`. The same row of the other bank is left as it was.
- R8: The choice counter at row `upd_pc` is left unchanged when `upd_bank` differs from the outcome but the selected bank counter's top bit, read before the update, matches the outcome.
- R9: In every other update, the choice counter at row `upd_pc` steps toward the outcome and saturates like R5.
- R10: The prediction is combinational from the registered tables. An update is visible from the next cycle. A prediction that reads an entry during the cycle it is written returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | IDX_W | Branch address bits for the lookup |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_bank | output | 1 | Bank that answered (1 = taken bank) |
| pred_idx | output | IDX_W | Bank row that was read |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | IDX_W | Address bits of the resolved branch (choice row) |
| upd_taken | input | 1 | Actual outcome |
| upd_idx | input | IDX_W | Bank row saved at prediction time |
| upd_bank | input | 1 | Bank saved at prediction time |

## Verification
The prediction outputs are combinational from the inputs and the tables. They settle within the same cycle that `pred_pc` changes, so the bench samples them one time step after it drives the address at a falling edge. An update takes effect at the rising edge where `upd_valid` is high. Its counter and history effects are therefore sampled at the next falling edge, after the bench recomputes the history and picks the address whose XOR lands on the row under test. The same-cycle case is checked on both sides of that rising edge: before it, the old value must appear, and after it, the new one.

// File: rtl/bimode_predictor.sv
module bimode_predictor #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 6,
  parameter int CNT_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] pred_pc,
  output logic             pred_taken,
  output logic             pred_bank,
  output logic [IDX_W-1:0] pred_idx,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_pc,
  input  logic             upd_taken,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_bank
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int MSB = CNT_W - 1;
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CMIN = '0;
  localparam logic [CNT_W-1:0] WEAK_T = CNT_W'(1) << MSB;
  localparam logic [CNT_W-1:0] WEAK_NT = WEAK_T - CNT_W'(1);

  logic [CNT_W-1:0]  nt_tbl [DEPTH];
  logic [CNT_W-1:0]  t_tbl  [DEPTH];
  logic [CNT_W-1:0]  ch_tbl [DEPTH];
  logic [HIST_W-1:0] hist;

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] c, input logic up);
    if (up) return (c == CMAX) ? c : c + CNT_W'(1);
    return (c == CMIN) ? c : c - CNT_W'(1);
  endfunction

  assign pred_idx   = pred_pc ^ IDX_W'(hist);
  assign pred_bank  = ch_tbl[pred_pc][MSB];
  assign pred_taken = pred_bank ? t_tbl[pred_idx][MSB] : nt_tbl[pred_idx][MSB];

  logic [CNT_W-1:0] sel_old;
  logic             ch_hold;

  assign sel_old = upd_bank ? t_tbl[upd_idx] : nt_tbl[upd_idx];
  assign ch_hold = (upd_bank != upd_taken) && (sel_old[MSB] == upd_taken);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        nt_tbl[i] <= WEAK_NT;
        t_tbl[i]  <= WEAK_T;
        ch_tbl[i] <= WEAK_T;
      end
      hist <= '0;
    end else if (upd_valid) begin
      if (upd_bank) t_tbl[upd_idx] <= sat_step(sel_old, upd_taken);
      else          nt_tbl[upd_idx] <= sat_step(sel_old, upd_taken);
      if (!ch_hold) ch_tbl[upd_pc] <= sat_step(ch_tbl[upd_pc], upd_taken);
      hist <= {hist[HIST_W-2:0], upd_taken};
    end
  end

  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> hist == {$past(hist[HIST_W-2:0]), $past(upd_taken)});

  assert_no_wrap_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && sel_old == CMAX) |=>
      (($past(upd_bank) ? t_tbl[$past(upd_idx)] : nt_tbl[$past(upd_idx)]) == CMAX));

  assert_no_wrap_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && sel_old == CMIN) |=>
      (($past(upd_bank) ? t_tbl[$past(upd_idx)] : nt_tbl[$past(upd_idx)]) == CMIN));

  assert_other_bank_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> ($past(upd_bank) ? (nt_tbl[$past(upd_idx)] == $past(nt_tbl[upd_idx]))
                                   : (t_tbl[$past(upd_idx)] == $past(t_tbl[upd_idx]))));

  assert_choice_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_bank != upd_taken &&
     (upd_bank ? t_tbl[upd_idx][MSB] : nt_tbl[upd_idx][MSB]) == upd_taken) |=>
      ch_tbl[$past(upd_pc)] == $past(ch_tbl[upd_pc]));

endmodule

// File: tb/bimode_predictor_bench.sv
`timescale 1ns/1ps
module bimode_predictor_bench;
  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IDX_W-1:0] pred_pc = '0;
  logic             pred_taken, pred_bank;
  logic [IDX_W-1:0] pred_idx;
  logic             upd_valid = 1'b0;
  logic [IDX_W-1:0] upd_pc = '0;
  logic             upd_taken = 1'b0;
  logic [IDX_W-1:0] upd_idx = '0;
  logic             upd_bank = 1'b0;

  int errors = 0;
  int checks = 0;
  logic [IDX_W-1:0] h = '0;

  always #2.5 clk = ~clk;

  bimode_predictor #(.IDX_W(IDX_W), .HIST_W(IDX_W), .CNT_W(2)) u_bimode_predictor (
    .clk(clk), .rst_n(rst_n),
    .pred_pc(pred_pc), .pred_taken(pred_taken), .pred_bank(pred_bank), .pred_idx(pred_idx),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_idx(upd_idx), .upd_bank(upd_bank));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; h = '0;
  endtask

  task automatic upd(input int pc, input bit tk, input int idx, input bit bank);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = IDX_W'(pc); upd_taken = tk;
    upd_idx = IDX_W'(idx); upd_bank = bank;
    @(negedge clk);
    upd_valid = 1'b0;
    h = {h[IDX_W-2:0], tk};
  endtask

  task automatic look(input int pc);
    pred_pc = IDX_W'(pc);
    #1;
  endtask

  task automatic test_reset();
    do_reset();
    look(4);
    chk("R1", "fresh bank", int'(pred_bank), 1);
    chk("R1", "fresh taken", int'(pred_taken), 1);
    chk("R2", "fresh idx", int'(pred_idx), 4);
  endtask

  task automatic test_sat_low();
    do_reset();
    upd(63, 0, 5, 1);
    look(5);
    chk("R4", "taken bank after one NT", int'(pred_taken), 0);
    upd(63, 0, 5, 1);
    upd(63, 0, 5, 1);
    look(5);
    chk("R5", "floor pred", int'(pred_taken), 0);
    upd(63, 1, 5, 1);
    upd(63, 1, 5, 1);
    look(5 ^ int'(h));
    chk("R2", "idx with history", int'(pred_idx), 5);
    chk("R5", "no wrap below zero", int'(pred_taken), 1);
  endtask

  task automatic test_sat_high();
    do_reset();
    repeat (3) upd(63, 1, 9, 1);
    look(9 ^ int'(h));
    chk("R5", "ceiling pred", int'(pred_taken), 1);
    upd(63, 0, 9, 1);
    look(9 ^ int'(h));
    chk("R5", "one below ceiling", int'(pred_taken), 1);
    upd(63, 0, 9, 1);
    look(9 ^ int'(h));
    chk("R5", "two below ceiling", int'(pred_taken), 0);
  endtask

  task automatic test_unselected();
    do_reset();
    upd(63, 0, 7, 0);
    upd(63, 0, 7, 0);
    look(7);
    chk("R7", "taken bank untouched", int'(pred_taken), 1);
  endtask

  task automatic test_choice_select();
    do_reset();
    upd(40, 1, 12, 0);
    upd(14, 0, 20, 1);
    look(14);
    chk("R9", "choice trained to NT bank", int'(pred_bank), 0);
    chk("R2", "idx after two updates", int'(pred_idx), 12);
    chk("R3", "NT bank supplies pred", int'(pred_taken), 1);
  endtask

  task automatic test_choice_hold();
    do_reset();
    upd(50, 0, 33, 1);
    upd(30, 0, 33, 1);
    look(30);
    chk("R8", "choice held", int'(pred_bank), 1);
    chk("R8", "taken bank pred", int'(pred_taken), 1);
  endtask

  task automatic test_same_cycle();
    do_reset();
    @(negedge clk);
    pred_pc = IDX_W'(11);
    upd_valid = 1'b1; upd_pc = IDX_W'(63); upd_taken = 1'b0;
    upd_idx = IDX_W'(11); upd_bank = 1'b1;
    #1;
    chk("R10", "old value during write", int'(pred_taken), 1);
    @(negedge clk);
    upd_valid = 1'b0;
    h = {h[IDX_W-2:0], 1'b0};
    #1;
    chk("R10", "new value next cycle", int'(pred_taken), 0);
    upd(63, 1, 0, 0);
    upd(63, 0, 0, 0);
    upd(63, 1, 0, 0);
    look(0);
    chk("R6", "history bits", int'(pred_idx), 5);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    test_reset();
    test_sat_low();
    test_sat_high();
    test_unselected();
    test_choice_select();
    test_choice_hold();
    test_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule